// File: doc/BRIEF.md
# SDI Scrambling Serializer

This block converts 10-bit parallel video words into a serial bit stream with ten bits per word. A clock-enable input, `bit_en`, pulses once per serial bit, so it runs at ten times the word rate. Each word is sent least significant bit first. The raw serial bits pass through a self-synchronizing scrambler with generator x^9 + x^4 + 1. An NRZ-to-NRZI stage follows the scrambler, and its output drives `ser_out` from a register. A receiver recovers the data by NRZI-decoding the stream and then descrambling it, with no framing information needed.

An 8-bit source fills the upper eight bits of the word, and the two low bits are replaced by zeros. A bypass input sends the unscrambled, un-NRZI'd serializer bits straight to the output, for transparent data transfer. A detector watches the loaded words for the timing-reference preamble 3FF, 000, 000 and raises a flag for one word period. The detector can be turned off for data that is not video. The block samples a word only on the enabled edge where it is loaded, and `word_take` marks that edge for the upstream source.

Top module: `sdi_scramble_ser`

## Requirements
- R1: `word_take` equals `bit_en` on every edge where the bit counter is at zero. A word is loaded on each such edge, so loads occur on every tenth enabled edge. The first enabled edge after reset loads a word.
- R2: `word_in` is sampled only on the load edge. Changes to it during the other nine bit periods of a word have no effect on the output.
- R3: On each enabled edge, `ser_out` updates with the next bit of the current word, taking bit 0 first. When `bit_en` is low, `ser_out` and `sync_flag` hold their values.
- R4: With `bypass` low, each raw bit r becomes the scrambled bit s = r XOR q[8] XOR q[3]. Here q is a 9-bit history of past scrambled bits: q[0] is the most recent, and s is shifted into q[0].
- R5: With `bypass` low, the registered NRZI level toggles when s is 1 and holds when s is 0. `ser_out` shows the new level.
- R6: When `narrow_mode` is high, the word used is {word_in[9:2], 2'b00}.
- R7: When `bypass` is high, `ser_out` shows the raw serializer bit of that edge.
- R8: On a load edge, if the word loaded two loads earlier has all of its significant bits set (bits 9:0, or bits 9:2 in narrow mode), and both the previous and the current loaded words are zero, `sync_flag` goes to 1. Otherwise it goes to 0. It changes only on load edges.
- R9: While `sync_off` is high, every load edge sets `sync_flag` to 0.
- R10: `rst_n` is a synchronous, active-low reset. It clears the bit counter, the scrambler history, the NRZI level, `ser_out` and `sync_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | One pulse per serial bit |
| word_in | input | 10 | Parallel video word |
| narrow_mode | input | 1 | 8-bit source in the upper bits |
| bypass | input | 1 | Send raw serializer bits to the output |
| sync_off | input | 1 | Disable preamble detection |
| ser_out | output | 1 | Serial output |
| word_take | output | 1 | High on the edge that loads a word |
| sync_flag | output | 1 | Preamble found, held for one word |

## Verification
On every cycle, the assertions check the following:
- the ten-edge load spacing and the load on the first enabled edge after reset;
- that the output and the flag hold while `bit_en` is low;
- the raw-bit path under bypass;
- that the flag changes only on load edges and stays clear while detection is off;
- that reset clears the output and the flag.

The scrambler and NRZI arithmetic are shown only by the bench's scenarios. The bench NRZI-decodes and descrambles the stream and compares the result bit by bit against every 10-bit word and every 8-bit word. The bench scenarios also cover preamble recognition under each mode, and the insensitivity to `word_in` mid-word.

// File: rtl/sdi_ser_pkg.sv
// Shared constants for the scrambling serializer.
// Assumes a 10-bit video word and a 9-stage scrambler.
package sdi_ser_pkg;
    localparam int SER_WORD_W   = 10;
    localparam int SER_NARROW_W = 8;
    localparam int SCR_LEN      = 9;
    localparam int SCR_TAP_HI   = 9;
    localparam int SCR_TAP_LO   = 4;
endpackage

// File: rtl/sdi_word_shifter.sv
// Parallel-to-serial converter. It loads a word when the bit counter is at zero
// and emits it LSB first, one bit per enabled edge.
// Assumes bit_en pulses at the serial rate. raw_bit is valid combinationally on
// each enabled edge.
module sdi_word_shifter #(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [WORD_W-1:0] word_d,
    output logic              raw_bit,
    output logic              word_take
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] sh_q;
    logic              at_load;

    // decode the load slot
    assign at_load   = (cnt_q == '0);
    assign word_take = bit_en && at_load;
    // bit presented on this edge
    assign raw_bit   = at_load ? word_d[0] : sh_q[0];

    // bit counter and shift register advance on each enabled edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sh_q  <= '0;
        end else if (bit_en) begin
            cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
            sh_q  <= at_load ? (word_d >> 1) : (sh_q >> 1);
        end
    end
endmodule

// File: rtl/sdi_sync_finder.sv
// Timing-reference preamble detector. It looks for all-ones, zero, zero
// across three consecutive loaded words.
// Assumes word_take marks each load. In narrow mode only the upper bits are
// significant.
module sdi_sync_finder #(
    parameter int WORD_W   = 10,
    parameter int NARROW_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_take,
    input  logic [WORD_W-1:0] word_d,
    input  logic              narrow,
    input  logic              sync_off,
    output logic              sync_flag
);
    localparam logic [WORD_W-1:0] FULL_MASK = '1;
    localparam logic [WORD_W-1:0] NAR_MASK  = FULL_MASK << (WORD_W - NARROW_W);

    logic [WORD_W-1:0] h1_q, h2_q;
    logic [WORD_W-1:0] mask;
    logic              match;

    // pick the significant-bit mask for the ones word
    assign mask  = narrow ? NAR_MASK : FULL_MASK;
    // preamble compare over the two older words and the incoming one
    assign match = !sync_off && ((h2_q & mask) == mask)
                   && (h1_q == '0) && (word_d == '0);

    // word history and flag update on each load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h1_q      <= '0;
            h2_q      <= '0;
            sync_flag <= 1'b0;
        end else if (word_take) begin
            h2_q      <= h1_q;
            h1_q      <= word_d;
            sync_flag <= match;
        end
    end
endmodule

// File: rtl/sdi_scr_nrzi.sv
// Self-synchronizing scrambler followed by an NRZI encoder and the output
// register, with a raw bypass.
// Assumes the taps count from 1 at the newest history bit. The state keeps
// advancing while bypass is high.
module sdi_scr_nrzi #(
    parameter int LEN    = 9,
    parameter int TAP_HI = 9,
    parameter int TAP_LO = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic raw_bit,
    input  logic bypass,
    output logic ser_out
);
    logic [LEN-1:0] hist_q;
    logic           lvl_q;
    logic           scr_bit;

    // scrambled bit from the two feedback taps
    assign scr_bit = raw_bit ^ hist_q[TAP_HI-1] ^ hist_q[TAP_LO-1];

    // history, NRZI level and output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q  <= '0;
            lvl_q   <= 1'b0;
            ser_out <= 1'b0;
        end else if (bit_en) begin
            hist_q  <= {hist_q[LEN-2:0], scr_bit};
            lvl_q   <= lvl_q ^ scr_bit;
            ser_out <= bypass ? raw_bit : (lvl_q ^ scr_bit);
        end
    end
endmodule

// File: rtl/sdi_scramble_ser.sv
// Top of the scrambling serializer. It maps 8-bit sources, then chains the
// word shifter, preamble detector and scrambler/NRZI stage.
// Assumes one clock, with bit_en pulsing once per serial bit.
module sdi_scramble_ser #(
    parameter int WORD_W   = sdi_ser_pkg::SER_WORD_W,
    parameter int NARROW_W = sdi_ser_pkg::SER_NARROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [WORD_W-1:0] word_in,
    input  logic              narrow_mode,
    input  logic              bypass,
    input  logic              sync_off,
    output logic              ser_out,
    output logic              word_take,
    output logic              sync_flag
);
    localparam int PAD_W = WORD_W - NARROW_W;

    logic [WORD_W-1:0] word_d;
    logic              raw_bit;

    // 8-bit sources sit in the upper bits with zero padding
    assign word_d = narrow_mode ? {word_in[WORD_W-1 -: NARROW_W], {PAD_W{1'b0}}}
                                : word_in;

    sdi_word_shifter #(.WORD_W(WORD_W)) i_shift (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .word_d(word_d),
        .raw_bit(raw_bit), .word_take(word_take)
    );

    sdi_sync_finder #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) i_sync (
        .clk(clk), .rst_n(rst_n), .word_take(word_take), .word_d(word_d),
        .narrow(narrow_mode), .sync_off(sync_off), .sync_flag(sync_flag)
    );

    sdi_scr_nrzi #(
        .LEN(sdi_ser_pkg::SCR_LEN),
        .TAP_HI(sdi_ser_pkg::SCR_TAP_HI),
        .TAP_LO(sdi_ser_pkg::SCR_TAP_LO)
    ) i_scr (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .raw_bit(raw_bit),
        .bypass(bypass), .ser_out(ser_out)
    );
endmodule

// File: rtl/sdi_scramble_ser_chk.sv
// Property checker for the scrambling serializer, bound to the top.
// Assumes it sees the top's ports plus the internal raw serializer bit.
module sdi_scramble_ser_chk #(
    parameter int WORD_W = 10
) (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic bypass,
    input logic sync_off,
    input logic ser_out,
    input logic word_take,
    input logic sync_flag,
    input logic raw_bit
);
    localparam int GAP_W = $clog2(WORD_W) + 2;

    logic [GAP_W-1:0] gap_q;
    logic             seen_q;

    // count enabled edges since the last load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (bit_en) begin
            if (word_take) begin
                gap_q  <= GAP_W'(1);
                seen_q <= 1'b1;
            end else begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    AST_FIRST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !seen_q) |-> word_take); // R1
    AST_LOAD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && seen_q) |-> (word_take == (gap_q == GAP_W'(WORD_W)))); // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(ser_out) && $stable(sync_flag))); // R3
    AST_BYPASS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && bypass) |=> (ser_out == $past(raw_bit))); // R7
    AST_SYNC_AT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !word_take |=> $stable(sync_flag)); // R8
    AST_SYNC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (word_take && sync_off) |=> !sync_flag); // R9
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!ser_out && !sync_flag)); // R10
endmodule

bind sdi_scramble_ser sdi_scramble_ser_chk #(.WORD_W(WORD_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bypass(bypass),
    .sync_off(sync_off), .ser_out(ser_out), .word_take(word_take),
    .sync_flag(sync_flag), .raw_bit(raw_bit)
);

// File: tb/test_sdi_scramble_ser.sv
`timescale 1ns/1ps
module test_sdi_scramble_ser;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic [9:0] word_in = '0;
    logic       narrow_mode = 1'b0;
    logic       bypass = 1'b0;
    logic       sync_off = 1'b0;
    logic       ser_out, word_take, sync_flag;

    int n_tests = 0;
    int n_fail  = 0;

    // receiver-side model state: previous line level, descrambler history,
    // and the two previous loaded words
    logic       prev_out;
    logic [8:0] dh;
    logic [9:0] h1, h2;

    always #2.5 clk = ~clk;

    sdi_scramble_ser i_sdi_scramble_ser (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .word_in(word_in),
        .narrow_mode(narrow_mode), .bypass(bypass), .sync_off(sync_off),
        .ser_out(ser_out), .word_take(word_take), .sync_flag(sync_flag)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reset, leaving the bench at a negative edge
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bit_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        prev_out = 1'b0; dh = '0; h1 = '0; h2 = '0;
        check(ser_out == 1'b0, "R10 ser_out after reset", ser_out, 0);
        check(sync_flag == 1'b0, "R10 sync_flag after reset", sync_flag, 0);
        check(word_take == 1'b0, "R1 word_take idle", word_take, 0);
    endtask

    // send one word over ten enabled edges; gap inserts an idle cycle after each
    task automatic send_word(input logic [9:0] w, input bit gap);
        logic [9:0] mw;
        logic [9:0] msk;
        logic       exp_sync, got, nrz, rec;
        mw  = narrow_mode ? {w[9:2], 2'b00} : w;
        msk = narrow_mode ? 10'h3FC : 10'h3FF;
        exp_sync = !sync_off && ((h2 & msk) == msk) && (h1 == '0) && (mw == '0);
        h2 = h1; h1 = mw;
        for (int b = 0; b < 10; b++) begin
            word_in = (b == 0) ? w : ~w;   // R2: junk after the load edge
            bit_en  = 1'b1;
            #0.5;
            check(word_take == (b == 0), "R1 word_take slot", word_take, (b == 0));
            @(posedge clk);
            @(negedge clk);
            got = ser_out;
            if (bypass) begin
                check(got == mw[b], "R7 bypass raw bit", got, mw[b]);
            end else begin
                nrz = got ^ prev_out;
                rec = nrz ^ dh[8] ^ dh[3];
                dh  = {dh[7:0], nrz};
                prev_out = got;
                if (narrow_mode)
                    check(rec == mw[b], "R6 R3 R4 R5 R2 narrow decode", rec, mw[b]);
                else
                    check(rec == mw[b], "R3 R4 R5 R2 decode", rec, mw[b]);
            end
            check(sync_flag == exp_sync, sync_off ? "R9 sync_flag off" : "R8 sync_flag",
                  sync_flag, exp_sync);
            if (gap) begin
                bit_en = 1'b0;
                @(posedge clk);
                @(negedge clk);
                check(ser_out == got, "R3 hold when idle", ser_out, got);
                check(sync_flag == exp_sync, "R3 sync hold when idle", sync_flag, exp_sync);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R3 R4 R5: every 10-bit word, back to back
        for (int i = 0; i < 1024; i++) send_word(10'(i), 1'b0);
        // R3: sparse enables
        for (int i = 0; i < 40; i++) send_word(10'((i * 37 + 5) % 1024), 1'b1);
        // R8: preamble and near misses
        send_word(10'h3FF, 0); send_word(10'h000, 0); send_word(10'h000, 0);
        send_word(10'h000, 0);
        send_word(10'h3FF, 0); send_word(10'h000, 0); send_word(10'h001, 0);
        send_word(10'h3FE, 0); send_word(10'h000, 0); send_word(10'h000, 0);
        // R9: detection disabled
        sync_off = 1'b1;
        send_word(10'h3FF, 0); send_word(10'h000, 0); send_word(10'h000, 0);
        sync_off = 1'b0;
        send_word(10'h155, 0);
        // R6: every 8-bit value with junk low bits
        narrow_mode = 1'b1;
        for (int i = 0; i < 256; i++) send_word(10'((i << 2) | (i & 3)), 1'b0);
        // R6 R8: narrow preamble, low bits ignored
        send_word(10'h3FD, 0); send_word(10'h002, 0); send_word(10'h001, 0);
        send_word(10'h2FF, 0); send_word(10'h000, 0); send_word(10'h000, 0);
        narrow_mode = 1'b0;
        // R7: bypass from a fresh reset
        do_reset();
        bypass = 1'b1;
        for (int i = 0; i < 64; i++) send_word(10'((i * 97 + 3) % 1024), i[0]);
        bypass = 1'b0;
        do_reset();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule